// File: doc/BRIEF.md
# Ring Bus Mediator

This block is the one special node on a bus built from two shoot-through rings, one carrying the bus clock and one carrying data. While the bus is quiet, it drives both ring outputs high and does nothing else. A member node asks for the bus by pulling the data ring low. The mediator sees the falling data input and starts a bus clock. That clock is derived from a free-running source clock through a programmable divider. The mediator then runs three arbitration cycles. It keeps the data ring broken during the first cycle, so that the requester nearest downstream wins. In the next two cycles it forwards data, which lets a node claim the bus through priority arbitration.

During the message the mediator forwards data and counts bits. A member can end the message by holding its clock output high through a low half of the bus clock. The mediator can also force an end itself, when the message reaches the configured maximum length or when arbitration finds no winner. Every end is marked in-band by an interjection: the clock is held high for five bus cycles while the data line toggles. Three control cycles follow. The first two carry the reason for the end. The mediator drives both of them low to report an error, and otherwise passes through the ACK or NAK that the members place on the ring. The third cycle restores the data line. After it the clock stops high and the bus is idle again.

Top module: `ring_mediator`

## Requirements
- R1: After reset and while idle with `data_in` high, `clk_out` and `data_out` are both 1 and `clk_out` does not toggle.
- R2: A 0 on `data_in` sampled while idle makes `clk_out` fall at that same source clock edge. Every low half of the bus clock lasts `div_cfg`+1 source clock cycles.
- R3: During the low half of the first arbitration cycle, `data_out` is 1 whatever the value of `data_in`.
- R4: If `data_in` is 1 at the end of the first arbitration low half (no winner), the mediator interjects at once with an error. The whole transaction then has exactly 4 rising edges on `clk_out`.
- R5: In the second and third arbitration cycles and throughout the data phase, `data_out` equals `data_in` combinationally.
- R6: A 1 on `clk_in` at the end of a data-phase low half starts an interjection. During it `clk_out` stays 1 for 10 half-periods and `data_out` runs 1,0 five times, which gives exactly 5 falling edges while the clock is high.
- R7: `max_len` (16 bits by default, so at least 8192 bits) caps the message length. After `max_len` data-phase rising edges, the next low half ends in a forced interjection with error, and a forced end takes precedence over a member request.
- R8: Three control cycles follow each interjection. On an error end, `data_out` is 0 in the first two. Otherwise `data_out` follows `data_in` in those two cycles. In the third, `data_out` is 1.
- R9: After the control phase, `clk_out` stays 1 and the bus is idle. A message with n data bits produces exactly n+7 rising edges on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W | Half-period length of the bus clock minus one, in source cycles |
| max_len | input | LEN_W | Maximum message length in data bits |
| clk_in | input | 1 | Clock ring input, returning from the last member |
| clk_out | output | 1 | Clock ring output, the generated bus clock |
| data_in | input | 1 | Data ring input, returning from the last member |
| data_out | output | 1 | Data ring output, driven or forwarded |

## Verification
The assertions take for granted that `div_cfg` and `max_len` hold still for the whole of a transaction. They also assume that both ring inputs are synchronous to the source clock and change only at the start of a bus-clock low half. The bench respects this by writing the configuration only while the bus is idle, and by driving `data_in` and the interjection hold on the falling source edge just after it sees `clk_out` fall. It sweeps several divider settings, a set of short length limits, every interjection point up to one bit past the limit, and null requests. From these parameters it works out, by arithmetic, the expected number of clock edges, the interjection toggles and the control-bit values.

// File: rtl/ring_mediator.sv
module ring_mediator #(
  parameter int DIV_W       = 8,
  parameter int LEN_W       = 16,
  parameter int ARB_CYCLES  = 3,
  parameter int INTJ_HALVES = 10,
  parameter int CTRL_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [LEN_W-1:0] max_len,
  input  logic             clk_in,
  output logic             clk_out,
  input  logic             data_in,
  output logic             data_out
);

  localparam int SEQ_A   = (ARB_CYCLES > CTRL_CYCLES) ? ARB_CYCLES : CTRL_CYCLES;
  localparam int SEQ_MAX = (SEQ_A > INTJ_HALVES) ? SEQ_A : INTJ_HALVES;
  localparam int CYC_W   = (SEQ_MAX > 2) ? $clog2(SEQ_MAX) : 1;
  localparam logic [CYC_W-1:0] ARB_LAST  = CYC_W'(ARB_CYCLES - 1);
  localparam logic [CYC_W-1:0] INTJ_LAST = CYC_W'(INTJ_HALVES - 1);
  localparam logic [CYC_W-1:0] CTRL_LAST = CYC_W'(CTRL_CYCLES - 1);
  localparam logic [CYC_W-1:0] CTRL_PEN  = CYC_W'(CTRL_CYCLES - 2);

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_DATA, S_INTJ, S_CTRL} st_t;

  st_t              state;
  logic [DIV_W-1:0] div_cnt;
  logic [CYC_W-1:0] cyc;
  logic [LEN_W-1:0] bit_cnt;
  logic             hi_q, err_q, clk_q, drv_q, fwd_q;

  wire tick     = (div_cnt == div_cfg);
  wire end_low  = tick && !hi_q;
  wire end_high = tick && hi_q;
  wire overflow = (bit_cnt >= max_len);

  assign clk_out  = clk_q;
  assign data_out = fwd_q ? data_in : drv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      div_cnt <= '0;
      cyc     <= '0;
      bit_cnt <= '0;
      hi_q    <= 1'b0;
      err_q   <= 1'b0;
      clk_q   <= 1'b1;
      drv_q   <= 1'b1;
      fwd_q   <= 1'b0;
    end else begin
      if (state == S_IDLE) div_cnt <= '0;
      else                 div_cnt <= tick ? '0 : div_cnt + 1'b1;

      case (state)
        S_IDLE: begin
          if (!data_in) begin
            state   <= S_ARB;
            clk_q   <= 1'b0;
            hi_q    <= 1'b0;
            cyc     <= '0;
            bit_cnt <= '0;
            err_q   <= 1'b0;
            fwd_q   <= 1'b0;
            drv_q   <= 1'b1;
          end
        end

        S_ARB: begin
          if (end_low) begin
            if (cyc == '0 && data_in) begin
              state <= S_INTJ;
              clk_q <= 1'b1;
              cyc   <= '0;
              err_q <= 1'b1;
              fwd_q <= 1'b0;
              drv_q <= 1'b1;
            end else begin
              clk_q <= 1'b1;
              hi_q  <= 1'b1;
            end
          end else if (end_high) begin
            clk_q <= 1'b0;
            hi_q  <= 1'b0;
            fwd_q <= 1'b1;
            if (cyc == ARB_LAST) begin
              state <= S_DATA;
              cyc   <= '0;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
        end

        S_DATA: begin
          if (end_low) begin
            if (overflow || clk_in) begin
              state <= S_INTJ;
              clk_q <= 1'b1;
              cyc   <= '0;
              err_q <= overflow;
              fwd_q <= 1'b0;
              drv_q <= 1'b1;
            end else begin
              clk_q   <= 1'b1;
              hi_q    <= 1'b1;
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (end_high) begin
            clk_q <= 1'b0;
            hi_q  <= 1'b0;
          end
        end

        S_INTJ: begin
          if (tick) begin
            if (cyc == INTJ_LAST) begin
              state <= S_CTRL;
              cyc   <= '0;
              hi_q  <= 1'b0;
              clk_q <= 1'b0;
              fwd_q <= !err_q;
              drv_q <= 1'b0;
            end else begin
              cyc   <= cyc + 1'b1;
              drv_q <= !drv_q;
            end
          end
        end

        S_CTRL: begin
          if (end_low) begin
            clk_q <= 1'b1;
            hi_q  <= 1'b1;
          end else if (end_high) begin
            if (cyc == CTRL_LAST) begin
              state <= S_IDLE;
              cyc   <= '0;
              hi_q  <= 1'b0;
              fwd_q <= 1'b0;
              drv_q <= 1'b1;
            end else begin
              cyc   <= cyc + 1'b1;
              clk_q <= 1'b0;
              hi_q  <= 1'b0;
              if (cyc == CTRL_PEN) begin
                fwd_q <= 1'b0;
                drv_q <= 1'b1;
              end else begin
                fwd_q <= !err_q;
                drv_q <= 1'b0;
              end
            end
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_IDLE) |-> (clk_out && $stable(clk_out))); // R1
  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (div_cnt <= div_cfg)); // R2
  AST_START_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(state) == S_IDLE && !$past(data_in)) |-> !clk_out); // R2
  AST_ARB_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARB && cyc == '0) |-> data_out); // R3
  AST_NULL_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTJ && $past(state) == S_ARB) |-> err_q); // R4
  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA || (state == S_ARB && cyc != '0)) |-> (data_out == data_in)); // R5
  AST_INTJ_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INTJ) |-> clk_out); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (bit_cnt <= max_len)); // R7
  AST_CTRL_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CTRL && err_q && cyc < CTRL_PEN + 1'b1) |-> !data_out); // R8
  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_CTRL && state == S_IDLE) |-> (clk_out && data_out)); // R9

endmodule

// File: tb/ring_mediator_tb_top.sv
`timescale 1ns/1ps
module ring_mediator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_cfg;
  logic [15:0] max_len;
  logic        data_in;
  logic        hold;
  logic        clk_out, data_out;
  wire         clk_in = clk_out | hold;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  ring_mediator dut_i (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .max_len(max_len),
    .clk_in(clk_in), .clk_out(clk_out), .data_in(data_in), .data_out(data_out)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int r, input int s);
    return ((r * 5 + s) % 3) != 0;
  endfunction

  // mode 0: member interjects after k bits; mode 1: run to length limit; mode 2: null request
  task automatic run_txn(input int div, input int ml, input int mode, input int k);
    int n, exp_r, base, r, low_len, hi_streak, falls_hi, badlow, guard;
    bit err, pclk, pdat;
    div_cfg = 8'(div);
    max_len = 16'(ml);
    data_in = 1'b1;
    hold    = 1'b0;
    @(negedge clk);
    if (mode == 2) begin
      n = 0; err = 1'b1; exp_r = 4; base = 1;
    end else begin
      if (mode == 1) begin n = ml; err = 1'b1; end
      else begin n = (k < ml) ? k : ml; err = (k >= ml); end
      exp_r = n + 7;
      base  = n + 4;
    end
    data_in = 1'b0;
    r = 0; pclk = 1'b1; pdat = data_out; low_len = 0; hi_streak = 0;
    falls_hi = 0; badlow = 0; guard = 0;
    while (hi_streak <= 12 * (div + 1) + 4 && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (clk_out && !pclk) begin
        r++;
        if (low_len != div + 1) badlow++;
        low_len = 0;
        if (mode == 0 && !err && r == 3 + k) hold = 1'b1;
      end
      if (!clk_out && pclk) begin
        if (r == 0) begin
          check(guard == 1, "R2", "cycles from request to clock fall", guard, 1);
          if (mode == 2) data_in = 1'b1;
          else begin
            #1 check(data_out == 1'b1, "R3", "data_out during first arbitration", int'(data_out), 1);
          end
        end else if (mode != 2 && r <= 3 + n) begin
          data_in = pat(r, div + k);
          #1 check(data_out == data_in, "R5", "forwarded data", int'(data_out), int'(data_in));
        end else if (r == base || r == base + 1) begin
          data_in = pat(r + 1, div);
          #1 check(data_out == (err ? 1'b0 : data_in), "R8", "control bit",
                   int'(data_out), int'(err ? 1'b0 : data_in));
        end else if (r == base + 2) begin
          data_in = 1'b1;
          #1 check(data_out == 1'b1, "R8", "final control cycle", int'(data_out), 1);
        end
      end
      if (clk_out && pclk && pdat && !data_out) begin
        falls_hi++;
        hold = 1'b0;
      end
      if (!clk_out) low_len++;
      hi_streak = clk_out ? hi_streak + 1 : 0;
      pclk = clk_out;
      pdat = data_out;
    end
    check(guard < 40000, "R9", "transaction finished", guard, 0);
    check(r == exp_r, (mode == 2) ? "R4" : ((mode == 1 || err) ? "R7" : "R9"),
          "clock rising edges", r, exp_r);
    check(falls_hi == 5, "R6", "data falls while clock held high", falls_hi, 5);
    check(badlow == 0, "R2", "low halves of wrong length", badlow, 0);
    check(clk_out && data_out, "R9", "lines high after return to idle", int'({clk_out, data_out}), 3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R9 watchdog expired: actual hung expected idle");
    finish_run();
  end

  initial begin
    int quiet_bad;
    rst_n = 1'b0; data_in = 1'b1; hold = 1'b0; div_cfg = '0; max_len = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(clk_out == 1'b1, "R1", "clk_out after reset", int'(clk_out), 1);
    check(data_out == 1'b1, "R1", "data_out after reset", int'(data_out), 1);
    quiet_bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!clk_out || !data_out) quiet_bad++;
    end
    check(quiet_bad == 0, "R1", "idle cycles with a low line", quiet_bad, 0);

    for (int div = 0; div < 3; div++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int ml;
        ml = (mi == 3) ? 5 : mi;
        for (int k = 0; k <= ml + 1; k++) run_txn(div, ml, 0, k);
        run_txn(div, ml, 1, 0);
        run_txn(div, ml, 2, 0);
      end
    end
    run_txn(0, 8192, 1, 0);
    finish_run();
  end

endmodule